// File: doc/BRIEF.md
# Flash Program and Erase Engine

This block is the self-timed write machinery that sits behind the command decoder of a small, parameterised NOR flash array model. The decoder opens a command frame with an operation code and a target address. For a program operation it then streams data bytes, and it closes the frame with a chip-select-rising indication that also says whether the frame ended on a byte boundary. If the write enable latch is set and the target is not protected, the engine holds a busy flag for a cycle count taken from parameters. On the last busy cycle it applies the change to its internal byte array and clears the write enable latch.

The array is divided into pages, sectors (a fixed number of pages) and blocks (a fixed number of sectors). A program operation collects bytes into a page buffer at a column that starts from the low address bits and wraps inside the page. It then ANDs the buffered bytes into the array. Sector, block and chip erase set whole regions to FFh. Chip erase leaves alone any sector that the per-sector lock mask from the protection unit marks as locked. A read port gives the decoder access to any byte of the array.

Top module: `fpe_engine`

## Requirements
- R1: Programming a byte stores the bitwise AND of the previous content and the supplied byte, so bits can only go from 1 to 0.
- R2: Program bytes land at consecutive columns starting at the column given by the low address bits. After the last column of the page the column returns to column 0 of the same page, and no other page changes.
- R3: When more bytes are streamed than the page holds, a later byte replaces the earlier buffered byte at the same wrapped column, and only the final buffered value is programmed.
- R4: Bytes of the target page that no streamed byte addressed keep their contents.
- R5: Sector erase (op code 1) sets every byte of the sector that contains the given address to FFh, whatever the offset of that address inside the sector. All other sectors are left unchanged.
- R6: Block erase (op code 2) sets every byte of the block that contains the given address to FFh and leaves other blocks unchanged.
- R7: Chip erase (op code 3) sets to FFh every sector whose lock mask bit is 0 and leaves sectors whose bit is 1 untouched.
- R8: With the write enable latch clear, a program (op code 0) or erase frame never raises busy and leaves the array unchanged.
- R9: An accepted frame raises busy on the cycle after chip-select rise. Busy stays high for `count*T_BYTE` cycles for a program, where count is the number of streamed bytes capped at the page size, and for `T_SECT`, `T_BLK` or `T_CHIP` cycles for an erase. The array changes only at the edge where busy falls.
- R10: The write enable latch reads 0 once an accepted program or erase finishes.
- R11: A chip-select rise with the boundary flag low, or a program frame with no data bytes, starts no cycle and leaves the latch set.
- R12: A program or sector erase aimed at a locked sector, or a block erase of a block that holds any locked sector, is rejected entirely: no busy, no array change, and the latch stays set.
- R13: While busy, new frames and latch set or clear requests are ignored.
- R14: After reset, busy and the latch are 0 and every byte of the array reads FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wel_set | input | 1 | Set the write enable latch (honoured only when idle) |
| wel_clr | input | 1 | Clear the write enable latch (honoured only when idle, wins over set) |
| cmd_valid | input | 1 | Opens a command frame |
| cmd_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| cmd_addr | input | ADDR_W | Target byte address |
| data_valid | input | 1 | A program data byte is present |
| data_byte | input | 8 | Program data byte |
| cs_rise | input | 1 | Closes the open frame |
| cs_aligned | input | 1 | The frame closed on a byte boundary |
| lock_mask | input | NSECT | One lock bit per sector, 1 = locked |
| busy | output | 1 | Operation in progress |
| wel | output | 1 | Write enable latch |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array byte at rd_addr |

## Verification
Program operations are swept over every page of the array twice. Start columns, lengths and byte patterns come from the page number. Some lengths go past the page size, so an unwrapped or unmerged write shows up as a wrong byte in the whole-array comparison. The second pass ANDs new data into bytes that already hold data, which separates an AND merge from a plain overwrite. Erases are issued at addresses inside the region rather than at its base, so any region decoding that depends on the low address bits is exposed. Lock masks, an unset latch, a frame that does not end on a byte boundary, an empty frame and traffic injected during busy are each checked against the busy length, the latch value and the array contents.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_BLK  = 2'd2,
        OP_CHIP = 2'd3
    } fpe_op_e;

    typedef enum logic [1:0] {
        M_IDLE = 2'd0,
        M_LOAD = 2'd1,
        M_RUN  = 2'd2
    } fpe_mode_e;

    function automatic int fpe_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpe_page_buf.sv
module fpe_page_buf #(
    parameter int PAGE_AW = 4,
    localparam int PAGE_BYTES = 1 << PAGE_AW,
    localparam int CW_W = $clog2(PAGE_BYTES + 1)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            init,
    input  logic [PAGE_AW-1:0]              init_col,
    input  logic                            push,
    input  logic [7:0]                      push_byte,
    output logic [PAGE_BYTES-1:0][7:0]      pg_data,
    output logic [PAGE_BYTES-1:0]           pg_mask,
    output logic [CW_W-1:0]                 pg_count
);

    typedef struct packed {
        logic [PAGE_BYTES-1:0][7:0] data;
        logic [PAGE_BYTES-1:0]      mask;
        logic [PAGE_AW-1:0]         col;
        logic [CW_W-1:0]            count;
    } pbuf_t;

    pbuf_t pb_d, pb_q;

    always_comb begin
        pb_d = pb_q;
        if (init) begin
            pb_d.mask  = '0;
            pb_d.col   = init_col;
            pb_d.count = '0;
        end else if (push) begin
            pb_d.data[pb_q.col] = push_byte;
            pb_d.mask[pb_q.col] = 1'b1;
            pb_d.col            = pb_q.col + 1'b1;
            if (pb_q.count != CW_W'(PAGE_BYTES)) begin
                pb_d.count = pb_q.count + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pb_q <= '0;
        end else begin
            pb_q <= pb_d;
        end
    end

    assign pg_data  = pb_q.data;
    assign pg_mask  = pb_q.mask;
    assign pg_count = pb_q.count;

endmodule

// File: rtl/fpe_busy_timer.sv
module fpe_busy_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/fpe_array.sv
module fpe_array
    import fpe_pkg::*;
#(
    parameter int PAGE_AW = 4,
    parameter int SECT_SH = 6,
    parameter int BLK_SH  = 8,
    parameter int ADDR_W  = 9,
    localparam int PAGE_BYTES = 1 << PAGE_AW,
    localparam int NBYTES = 1 << ADDR_W,
    localparam int NSECT = 1 << (ADDR_W - SECT_SH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       commit,
    input  fpe_op_e                    op,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [PAGE_BYTES-1:0][7:0] pg_data,
    input  logic [PAGE_BYTES-1:0]      pg_mask,
    input  logic [NSECT-1:0]           lock_mask,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [7:0]                 rd_data
);

    logic [NBYTES-1:0][7:0] mem_d, mem_q;
    int tgt_sect, tgt_blk;

    always_comb begin
        mem_d    = mem_q;
        tgt_sect = int'(addr) >> SECT_SH;
        tgt_blk  = int'(addr) >> BLK_SH;
        if (commit) begin
            if (op == OP_PROG) begin
                for (int i = 0; i < PAGE_BYTES; i++) begin
                    if (pg_mask[i]) begin
                        mem_d[{addr[ADDR_W-1:PAGE_AW], PAGE_AW'(i)}] =
                            mem_q[{addr[ADDR_W-1:PAGE_AW], PAGE_AW'(i)}] & pg_data[i];
                    end
                end
            end else begin
                for (int j = 0; j < NBYTES; j++) begin
                    if (!lock_mask[j >> SECT_SH] &&
                        ((op == OP_CHIP) ||
                         (op == OP_SECT && (j >> SECT_SH) == tgt_sect) ||
                         (op == OP_BLK  && (j >> BLK_SH)  == tgt_blk))) begin
                        mem_d[j] = 8'hFF;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '1;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/fpe_engine.sv
module fpe_engine
    import fpe_pkg::*;
#(
    parameter int PAGE_AW         = 4,
    parameter int PG_PER_SECT_AW  = 2,
    parameter int SECT_PER_BLK_AW = 2,
    parameter int BLK_AW          = 1,
    parameter int T_BYTE          = 2,
    parameter int T_SECT          = 16,
    parameter int T_BLK           = 24,
    parameter int T_CHIP          = 32,
    localparam int PAGE_BYTES = 1 << PAGE_AW,
    localparam int SECT_SH    = PAGE_AW + PG_PER_SECT_AW,
    localparam int BLK_SH     = SECT_SH + SECT_PER_BLK_AW,
    localparam int ADDR_W     = BLK_SH + BLK_AW,
    localparam int NSECT      = 1 << (ADDR_W - SECT_SH),
    localparam int CW_W       = $clog2(PAGE_BYTES + 1),
    localparam int CNT_MAX    = fpe_max(fpe_max(T_CHIP, T_BLK),
                                        fpe_max(T_SECT, PAGE_BYTES * T_BYTE)),
    localparam int CNT_W      = $clog2(CNT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wel_set,
    input  logic              wel_clr,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              data_valid,
    input  logic [7:0]        data_byte,
    input  logic              cs_rise,
    input  logic              cs_aligned,
    input  logic [NSECT-1:0]  lock_mask,
    output logic              busy,
    output logic              wel,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    typedef struct packed {
        fpe_mode_e         mode;
        fpe_op_e           op;
        logic [ADDR_W-1:0] addr;
        logic              wel;
    } ctl_t;

    ctl_t st_d, st_q;

    logic                       pb_init, pb_push;
    logic [PAGE_BYTES-1:0][7:0] pg_data;
    logic [PAGE_BYTES-1:0]      pg_mask;
    logic [CW_W-1:0]            pg_count;
    logic                       tmr_load, tmr_done;
    logic [CNT_W-1:0]           dur;
    logic                       blk_locked, tgt_locked, go, commit;

    // Protection lookup for the captured target
    always_comb begin
        blk_locked = 1'b0;
        for (int s = 0; s < NSECT; s++) begin
            if ((s >> SECT_PER_BLK_AW) == int'(st_q.addr[ADDR_W-1:BLK_SH])) begin
                blk_locked = blk_locked | lock_mask[s];
            end
        end
        unique case (st_q.op)
            OP_PROG, OP_SECT: tgt_locked = lock_mask[st_q.addr[ADDR_W-1:SECT_SH]];
            OP_BLK:           tgt_locked = blk_locked;
            default:          tgt_locked = 1'b0;
        endcase
        unique case (st_q.op)
            OP_PROG: dur = CNT_W'(pg_count) * CNT_W'(T_BYTE);
            OP_SECT: dur = CNT_W'(T_SECT);
            OP_BLK:  dur = CNT_W'(T_BLK);
            default: dur = CNT_W'(T_CHIP);
        endcase
    end

    // Next-state computation for the frame and busy controller
    always_comb begin
        st_d     = st_q;
        pb_init  = 1'b0;
        pb_push  = 1'b0;
        commit   = 1'b0;
        go       = 1'b0;
        unique case (st_q.mode)
            M_IDLE: begin
                if (wel_clr) begin
                    st_d.wel = 1'b0;
                end else if (wel_set) begin
                    st_d.wel = 1'b1;
                end
                if (cmd_valid) begin
                    st_d.mode = M_LOAD;
                    st_d.op   = fpe_op_e'(cmd_op);
                    st_d.addr = cmd_addr;
                    pb_init   = 1'b1;
                end
            end
            M_LOAD: begin
                pb_push = data_valid && (st_q.op == OP_PROG);
                if (cs_rise) begin
                    go = cs_aligned && st_q.wel && !tgt_locked &&
                         ((st_q.op != OP_PROG) || (pg_count != '0));
                    st_d.mode = go ? M_RUN : M_IDLE;
                end
            end
            default: begin
                if (tmr_done) begin
                    commit    = 1'b1;
                    st_d.wel  = 1'b0;
                    st_d.mode = M_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: M_IDLE, op: OP_PROG, addr: '0, wel: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign tmr_load = go;
    assign busy     = (st_q.mode == M_RUN);
    assign wel      = st_q.wel;

    fpe_page_buf #(.PAGE_AW(PAGE_AW)) u_pbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .init      (pb_init),
        .init_col  (cmd_addr[PAGE_AW-1:0]),
        .push      (pb_push),
        .push_byte (data_byte),
        .pg_data   (pg_data),
        .pg_mask   (pg_mask),
        .pg_count  (pg_count)
    );

    fpe_busy_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (dur),
        .done     (tmr_done)
    );

    fpe_array #(
        .PAGE_AW (PAGE_AW),
        .SECT_SH (SECT_SH),
        .BLK_SH  (BLK_SH),
        .ADDR_W  (ADDR_W)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .op        (st_q.op),
        .addr      (st_q.addr),
        .pg_data   (pg_data),
        .pg_mask   (pg_mask),
        .lock_mask (lock_mask),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/fpe_engine_chk.sv
module fpe_engine_chk #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_rise,
    input logic              cs_aligned,
    input logic              busy,
    input logic              wel,
    input logic              tgt_locked,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        rd_data
);

    a_r9_busy_after_close: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_rise));

    a_r8_busy_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wel));

    a_r10_latch_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    a_r13_latch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(wel));

    a_r11_unaligned_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && !cs_aligned && !busy) |=> !busy);

    a_r12_locked_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && tgt_locked && !busy) |=> !busy);

    a_r9_array_still_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $stable(rd_addr)) |-> $stable(rd_data));

endmodule

bind fpe_engine fpe_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_rise    (cs_rise),
    .cs_aligned (cs_aligned),
    .busy       (busy),
    .wel        (wel),
    .tgt_locked (tgt_locked),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data)
);

// File: tb/fpe_engine_test.sv
`timescale 1ns/1ps
module fpe_engine_test;

    localparam int PG     = 16;
    localparam int SECT   = 64;
    localparam int BLK    = 256;
    localparam int NB     = 512;
    localparam int NPAGES = NB / PG;
    localparam int TB_BYTE = 2;
    localparam int TB_SECT = 16;
    localparam int TB_BLK  = 24;
    localparam int TB_CHIP = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wel_set = 1'b0, wel_clr = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [8:0] cmd_addr = '0;
    logic       data_valid = 1'b0;
    logic [7:0] data_byte = '0;
    logic       cs_rise = 1'b0, cs_aligned = 1'b0;
    logic [7:0] lock_mask = '0;
    logic       busy, wel;
    logic [8:0] rd_addr = '0;
    logic [7:0] rd_data;

    int vectors = 0;
    int fails = 0;
    logic [7:0] ref_mem [NB];

    always #10 clk = ~clk;

    fpe_engine #(
        .T_BYTE(TB_BYTE), .T_SECT(TB_SECT), .T_BLK(TB_BLK), .T_CHIP(TB_CHIP)
    ) uut (
        .clk(clk), .rst_n(rst_n), .wel_set(wel_set), .wel_clr(wel_clr),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .data_valid(data_valid), .data_byte(data_byte),
        .cs_rise(cs_rise), .cs_aligned(cs_aligned), .lock_mask(lock_mask),
        .busy(busy), .wel(wel), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] gen(input int seed, input int k);
        return 8'((seed * 73 + k * 29 + 17) ^ (k << 3) ^ (seed >> 2));
    endfunction

    task automatic compare_all(input string req);
        for (int a = 0; a < NB; a++) begin
            rd_addr = 9'(a);
            #0.01;
            chk(rd_data === ref_mem[a], req, int'(rd_data), int'(ref_mem[a]));
        end
    endtask

    task automatic latch_on();
        @(negedge clk) wel_set = 1'b1;
        @(negedge clk) wel_set = 1'b0;
    endtask

    // Reference model of a program frame; returns the expected busy length
    task automatic model_prog(input int addr, input int n, input int seed, output int d);
        logic [7:0] b [PG];
        bit m [PG];
        int col = addr % PG;
        int base = addr - col;
        for (int i = 0; i < PG; i++) begin m[i] = 1'b0; b[i] = 8'h00; end
        for (int k = 0; k < n; k++) begin
            b[col] = gen(seed, k);
            m[col] = 1'b1;
            col = (col + 1) % PG;
        end
        for (int i = 0; i < PG; i++) if (m[i]) ref_mem[base + i] = ref_mem[base + i] & b[i];
        d = ((n > PG) ? PG : n) * TB_BYTE;
    endtask

    task automatic model_erase(input int op, input int addr);
        for (int j = 0; j < NB; j++) begin
            if (!lock_mask[j / SECT] &&
                ((op == 3) || (op == 1 && j / SECT == addr / SECT) ||
                 (op == 2 && j / BLK == addr / BLK)))
                ref_mem[j] = 8'hFF;
        end
    endtask

    task automatic run_cmd(input int op, input int addr, input int n, input int seed,
                           input bit aligned, input int exp_dur, input bit poke,
                           input string req);
        int cnt = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_addr = 9'(addr);
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int k = 0; k < n; k++) begin
            data_valid = 1'b1; data_byte = gen(seed, k);
            @(negedge clk);
        end
        data_valid = 1'b0;
        cs_rise = 1'b1; cs_aligned = aligned;
        @(negedge clk);
        cs_rise = 1'b0; cs_aligned = 1'b0;
        while (busy === 1'b1 && cnt < 5000) begin
            cnt++;
            if (poke) begin
                if (cnt == 1) begin
                    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_addr = 9'd0; wel_clr = 1'b1;
                end else if (cnt == 2) begin
                    cmd_valid = 1'b0; wel_clr = 1'b0;
                    data_valid = 1'b1; data_byte = 8'h00; cs_rise = 1'b1; cs_aligned = 1'b1;
                end else if (cnt == 3) begin
                    data_valid = 1'b0; cs_rise = 1'b0; cs_aligned = 1'b0;
                    chk(wel === 1'b1, "R13 latch held during busy", int'(wel), 1);
                end
            end
            @(negedge clk);
        end
        chk(cnt == exp_dur, {req, " busy length"}, cnt, exp_dur);
    endtask

    initial begin
        int d;
        for (int a = 0; a < NB; a++) ref_mem[a] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0, "R14 busy after reset", int'(busy), 0);
        chk(wel === 1'b0, "R14 latch after reset", int'(wel), 0);
        compare_all("R14 erased array after reset");

        // R8: no latch, program is ignored
        run_cmd(0, 37, 5, 99, 1'b1, 0, 1'b0, "R8");
        compare_all("R8 array untouched");

        // R1/R2/R3/R4/R9/R10: first program sweep over every page
        for (int p = 0; p < NPAGES; p++) begin
            int addr = p * PG + (p * 5) % PG;
            int n = 1 + (p * 7) % 23;
            latch_on();
            model_prog(addr, n, p, d);
            run_cmd(0, addr, n, p, 1'b1, d, 1'b0, "R9 program");
            chk(wel === 1'b0, "R10 latch after program", int'(wel), 0);
        end
        compare_all("R2/R3/R4 first program sweep");

        // R1: second sweep ANDs into programmed bytes
        for (int p = 0; p < NPAGES; p++) begin
            int addr = p * PG + (p * 3 + 1) % PG;
            int n = 1 + (p * 11) % 9;
            latch_on();
            model_prog(addr, n, p + 200, d);
            run_cmd(0, addr, n, p + 200, 1'b1, d, 1'b0, "R9 program");
        end
        compare_all("R1 AND merge sweep");

        // R5 with injected traffic during busy (R13)
        latch_on();
        model_erase(1, 165);
        run_cmd(1, 165, 0, 0, 1'b1, TB_SECT, 1'b1, "R5/R13 sector erase");
        chk(wel === 1'b0, "R10 latch after sector erase", int'(wel), 0);
        compare_all("R5/R13 sector erase result");

        // R6 block erase from a mid-block address
        latch_on();
        model_erase(2, 100);
        run_cmd(2, 100, 0, 0, 1'b1, TB_BLK, 1'b0, "R6 block erase");
        compare_all("R6 block erase result");

        // refill pages in sectors 0 and 5
        latch_on();
        model_prog(3, 10, 7, d);
        run_cmd(0, 3, 10, 7, 1'b1, d, 1'b0, "R9 program");
        latch_on();
        model_prog(330, 16, 8, d);
        run_cmd(0, 330, 16, 8, 1'b1, d, 1'b0, "R9 program");
        compare_all("R2 refill");

        // R11: unaligned close and empty program
        latch_on();
        run_cmd(0, 40, 3, 5, 1'b0, 0, 1'b0, "R11 unaligned");
        chk(wel === 1'b1, "R11 latch kept after unaligned", int'(wel), 1);
        run_cmd(0, 40, 0, 5, 1'b1, 0, 1'b0, "R11 empty program");
        chk(wel === 1'b1, "R11 latch kept after empty", int'(wel), 1);
        compare_all("R11 array untouched");

        // R12: locked targets
        lock_mask = 8'b0010_0000;
        run_cmd(0, 330, 4, 9, 1'b1, 0, 1'b0, "R12 locked program");
        run_cmd(1, 350, 0, 0, 1'b1, 0, 1'b0, "R12 locked sector erase");
        run_cmd(2, 300, 0, 0, 1'b1, 0, 1'b0, "R12 locked block erase");
        chk(wel === 1'b1, "R12 latch kept", int'(wel), 1);
        compare_all("R12 array untouched");
        model_erase(1, 260);
        run_cmd(1, 260, 0, 0, 1'b1, TB_SECT, 1'b0, "R12 unlocked neighbour erase");
        compare_all("R12 neighbour sector erased");

        // R7: chip erase skips locked sectors
        lock_mask = 8'b0010_0001;
        latch_on();
        model_erase(3, 0);
        run_cmd(3, 123, 0, 0, 1'b1, TB_CHIP, 1'b0, "R7 chip erase");
        chk(wel === 1'b0, "R10 latch after chip erase", int'(wel), 0);
        compare_all("R7 chip erase result");
        lock_mask = '0;

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule